// File: doc/BRIEF.md
# Parallel NOR Flash Query Probe

This block is a hardware sequencer that discovers a parallel NOR flash on a plain memory-mapped flash bus, using the common flash query mechanism. A single `start` pulse launches a probe. Each query byte is fetched in three bus operations: the block enters query mode, reads one location, and returns the device to read-array mode. Every address it drives is aligned to the bus width under test.

The probe first settles the bus width. It either tries 1, 2 and 4 bytes in turn, or it tests a single width chosen by the caller. It then confirms the three-character identification string and collects the 16-bit command-set code, the size exponent and the 16-bit interface code. The interface code plus one must have the bit of the detected width set. When the probe ends, a one-cycle `done` pulse is raised. At that point the width, command set, size and an ok flag with an error code are presented, and they stay unchanged until the next accepted start. The query offsets and command bytes are parameters.

Top module: `nfq_probe`

## Requirements
- R1: Each query byte takes three bus operations on consecutive cycles: a write of `QRY_CMD` at `QRY_ADDR` times the width, a read at the byte offset times the width, and a write of `EXIT_CMD` at address 0. The byte used is `fl_rdata[7:0]`. No write carries any other data value.
- R2: On every access, address bits below log2(width) are zero.
- R3: With `preset_width` = 0, widths 1, 2 and 4 are tried in that order at offset `OFS_ID`, and the probe stops at the first width that returns 0x51 ('Q'). If no width returns 0x51, the probe ends with `err_code` = 1 and `width_bytes` = 0.
- R4: With `preset_width` of 1, 2 or 4, only that width is tried, and a missing 0x51 gives `err_code` = 1 after one byte. Any other nonzero preset gives `err_code` = 1 with no bus access at all.
- R5: Offsets `OFS_ID`+1 and `OFS_ID`+2 must return 0x52 ('R') and 0x59 ('Y'). Otherwise the probe ends with `err_code` = 2 and the found width is kept.
- R6: `cmd_set` takes its low byte from `OFS_VEND` and its high byte from `OFS_VEND`+1.
- R7: `size_log2` is the byte at `OFS_SIZE`. `size_bytes` is 2 to that power, or 0 when the exponent is not below `SZW`.
- R8: The interface code has its low byte at `OFS_IFACE` and its high byte at `OFS_IFACE`+1. The sum (code + 1) mod 65536 is ANDed with the width in bytes. A zero result gives `err_code` = 3. A nonzero result gives `ok` = 1 and `err_code` = 0.
- R9: `done` is high for exactly one cycle per probe. All result outputs hold still while idle, until a start is accepted.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle. A start while busy is ignored, and the bus is quiet whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a probe (accepted when idle) |
| preset_width | input | 3 | 0 = auto-detect, 1/2/4 = fixed width |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Probe succeeded |
| err_code | output | 2 | 0 none, 1 no 'Q', 2 bad 'R'/'Y', 3 width unsupported |
| width_bytes | output | 3 | Width under test / detected width |
| cmd_set | output | 16 | Vendor command-set code |
| size_log2 | output | 8 | Device size exponent |
| size_bytes | output | SZW | Device size in bytes |
| fl_addr | output | AW | Flash byte address |
| fl_wr | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, valid in the read cycle |

## Verification
The hardest situation to reach is a width fallback in which the narrow attempts fail for the right reason. A wider device must ignore the query command when it is sent at the narrow-scaled address, so the 'Q' read returns array data. The bench flash model enters query mode only when the command arrives at its own scaled address, and it counts reads and writes. This exposes how many widths were tried for x1, x2, x4 and absent devices. The interface wrap case, code 0xFFFF, is reached by loading that value into the model's table.

// File: rtl/nfq_pkg.sv
// Package: shared types and constants of the flash query probe.
// Assumes: identification characters are ASCII, one byte per query location.
package nfq_pkg;
    typedef enum logic [1:0] {E_IDLE, E_ENTER, E_READ, E_EXIT} eng_st_e;
    typedef enum logic [1:0] {P_IDLE, P_ISSUE, P_WAIT, P_FIN} phase_e;
    typedef enum logic [2:0] {K_ID_Q, K_ID_R, K_ID_Y, K_VLO, K_VHI,
                              K_SIZE, K_ILO, K_IHI} step_e;
    typedef enum logic [1:0] {ERR_NONE, ERR_NO_Q, ERR_NO_RY, ERR_IFACE} err_e;

    localparam logic [7:0] CH_Q = 8'h51;
    localparam logic [7:0] CH_R = 8'h52;
    localparam logic [7:0] CH_Y = 8'h59;

    // True for the preset values the probe accepts.
    function automatic logic preset_ok(input logic [2:0] p);
        return (p == 3'd0) || (p == 3'd1) || (p == 3'd2) || (p == 3'd4);
    endfunction
endpackage

// File: rtl/nfq_qry_engine.sv
// Query engine: fetches one query byte with enter / read / exit bus cycles.
// Assumes: width is 1, 2 or 4 and stays constant while a byte is in flight;
// requests are accepted only in E_IDLE. ack pulses in the exit cycle.
module nfq_qry_engine
    import nfq_pkg::*;
#(
    parameter int         AW       = 24,
    parameter int         DW       = 32,
    parameter logic [7:0] QRY_ADDR = 8'h55,
    parameter logic [7:0] QRY_CMD  = 8'h98,
    parameter logic [7:0] EXIT_CMD = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [7:0]    ofs,
    input  logic [2:0]    width,
    output logic          ack,
    output logic [7:0]    qbyte,
    output logic [AW-1:0] fl_addr,
    output logic          fl_wr,
    output logic          fl_rd,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata
);
    localparam int ALIGN_BITS = 2;

    eng_st_e       st;
    logic [7:0]    ofs_q;
    logic [7:0]    byte_q;
    logic [AW-1:0] raw_addr;

    // Scale a query offset by the bus width in bytes.
    function automatic logic [AW-1:0] scale(input logic [7:0] o, input logic [2:0] w);
        logic [AW-1:0] b;
        b = AW'(o);
        case (w)
            3'd2:    return b << 1;
            3'd4:    return b << 2;
            default: return b;
        endcase
    endfunction

    // Step through the three bus operations of one query byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= E_IDLE;
            ofs_q  <= '0;
            byte_q <= '0;
        end else begin
            case (st)
                E_IDLE:  if (req) begin
                             st    <= E_ENTER;
                             ofs_q <= ofs;
                         end
                E_ENTER: st <= E_READ;
                E_READ:  begin
                             st     <= E_EXIT;
                             byte_q <= fl_rdata[7:0];
                         end
                default: st <= E_IDLE;
            endcase
        end
    end

    // Pick the unaligned address of the current operation.
    always_comb begin
        case (st)
            E_ENTER: raw_addr = scale(QRY_ADDR, width);
            E_READ:  raw_addr = scale(ofs_q, width);
            default: raw_addr = '0;
        endcase
    end

    // Clear low address bits below log2(width).
    for (genvar i = 0; i < AW; i++) begin : g_align
        if (i < ALIGN_BITS) begin : g_low
            localparam logic [2:0] LIM = 3'(1 << i);
            assign fl_addr[i] = raw_addr[i] & (width <= LIM);
        end else begin : g_high
            assign fl_addr[i] = raw_addr[i];
        end
    end

    // Bus strobes and data follow the state.
    always_comb begin
        fl_wr    = (st == E_ENTER) || (st == E_EXIT);
        fl_rd    = (st == E_READ);
        fl_wdata = '0;
        if (st == E_ENTER) fl_wdata = DW'(QRY_CMD);
        if (st == E_EXIT)  fl_wdata = DW'(EXIT_CMD);
    end

    assign ack   = (st == E_EXIT);
    assign qbyte = byte_q;
endmodule

// File: rtl/nfq_size_dec.sv
// Size decoder: turns a size exponent into a one-hot byte count.
// Assumes: an exponent at or beyond SZW yields zero.
module nfq_size_dec #(
    parameter int SZW = 32
) (
    input  logic [7:0]     exp_in,
    output logic [SZW-1:0] bytes_out
);
    // One comparator per result bit.
    for (genvar i = 0; i < SZW; i++) begin : g_bit
        assign bytes_out[i] = (exp_in == 8'(i));
    end
endmodule

// File: rtl/nfq_seq.sv
// Probe sequencer: walks widths and query fields, judges the results.
// Assumes: the engine acks every request; results are held after done.
module nfq_seq
    import nfq_pkg::*;
#(
    parameter logic [7:0] OFS_ID    = 8'h10,
    parameter logic [7:0] OFS_VEND  = 8'h13,
    parameter logic [7:0] OFS_SIZE  = 8'h27,
    parameter logic [7:0] OFS_IFACE = 8'h28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  preset_width,
    input  logic        ack,
    input  logic [7:0]  qbyte,
    output logic        req,
    output logic [7:0]  ofs,
    output logic        busy,
    output logic        done,
    output logic        ok,
    output logic [1:0]  err_code,
    output logic [2:0]  width_bytes,
    output logic [15:0] cmd_set,
    output logic [7:0]  size_log2
);
    phase_e      phase;
    step_e       step;
    err_e        err;
    logic        auto_w;
    logic        ok_q;
    logic [2:0]  cur_w;
    logic [7:0]  iface_lo;
    logic [15:0] iface_sum;
    logic        iface_fit;

    // Query offset of the current step.
    always_comb begin
        case (step)
            K_ID_Q:  ofs = OFS_ID;
            K_ID_R:  ofs = OFS_ID + 8'd1;
            K_ID_Y:  ofs = OFS_ID + 8'd2;
            K_VLO:   ofs = OFS_VEND;
            K_VHI:   ofs = OFS_VEND + 8'd1;
            K_SIZE:  ofs = OFS_SIZE;
            K_ILO:   ofs = OFS_IFACE;
            default: ofs = OFS_IFACE + 8'd1;
        endcase
    end

    // Interface code plus one, tested against the width bit.
    assign iface_sum = {qbyte, iface_lo} + 16'd1;
    assign iface_fit = |(iface_sum[2:0] & cur_w);

    // Main probe state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= P_IDLE;
            step     <= K_ID_Q;
            err      <= ERR_NONE;
            auto_w   <= 1'b0;
            ok_q     <= 1'b0;
            cur_w    <= '0;
            iface_lo <= '0;
            cmd_set  <= '0;
            size_log2 <= '0;
        end else begin
            case (phase)
                P_IDLE: if (start) begin
                    cmd_set   <= '0;
                    size_log2 <= '0;
                    iface_lo  <= '0;
                    ok_q      <= 1'b0;
                    step      <= K_ID_Q;
                    auto_w    <= (preset_width == 3'd0);
                    if (preset_ok(preset_width)) begin
                        err   <= ERR_NONE;
                        cur_w <= (preset_width == 3'd0) ? 3'd1 : preset_width;
                        phase <= P_ISSUE;
                    end else begin
                        err   <= ERR_NO_Q;
                        cur_w <= '0;
                        phase <= P_FIN;
                    end
                end
                P_ISSUE: phase <= P_WAIT;
                P_WAIT: if (ack) begin
                    phase <= P_ISSUE;
                    case (step)
                        K_ID_Q: begin
                            if (qbyte == CH_Q) begin
                                step <= K_ID_R;
                            end else if (auto_w && cur_w != 3'd4) begin
                                cur_w <= cur_w << 1;
                            end else begin
                                err   <= ERR_NO_Q;
                                cur_w <= '0;
                                phase <= P_FIN;
                            end
                        end
                        K_ID_R, K_ID_Y: begin
                            if (qbyte == ((step == K_ID_R) ? CH_R : CH_Y)) begin
                                step <= (step == K_ID_R) ? K_ID_Y : K_VLO;
                            end else begin
                                err   <= ERR_NO_RY;
                                phase <= P_FIN;
                            end
                        end
                        K_VLO: begin
                            cmd_set[7:0] <= qbyte;
                            step <= K_VHI;
                        end
                        K_VHI: begin
                            cmd_set[15:8] <= qbyte;
                            step <= K_SIZE;
                        end
                        K_SIZE: begin
                            size_log2 <= qbyte;
                            step <= K_ILO;
                        end
                        K_ILO: begin
                            iface_lo <= qbyte;
                            step <= K_IHI;
                        end
                        default: begin
                            phase <= P_FIN;
                            if (iface_fit) begin
                                ok_q <= 1'b1;
                                err  <= ERR_NONE;
                            end else begin
                                err  <= ERR_IFACE;
                            end
                        end
                    endcase
                end
                default: phase <= P_IDLE;
            endcase
        end
    end

    assign req         = (phase == P_ISSUE);
    assign busy        = (phase != P_IDLE);
    assign done        = (phase == P_FIN);
    assign ok          = ok_q;
    assign err_code    = err;
    assign width_bytes = cur_w;
endmodule

// File: rtl/nfq_probe.sv
// Top: flash query probe. Joins the sequencer, the bus engine and the
// size decoder. Assumes a flash bus with single-cycle reads (data valid
// in the cycle the read strobe is high).
module nfq_probe #(
    parameter int         AW        = 24,
    parameter int         DW        = 32,
    parameter int         SZW       = 32,
    parameter logic [7:0] QRY_ADDR  = 8'h55,
    parameter logic [7:0] QRY_CMD   = 8'h98,
    parameter logic [7:0] EXIT_CMD  = 8'hFF,
    parameter logic [7:0] OFS_ID    = 8'h10,
    parameter logic [7:0] OFS_VEND  = 8'h13,
    parameter logic [7:0] OFS_SIZE  = 8'h27,
    parameter logic [7:0] OFS_IFACE = 8'h28
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     preset_width,
    output logic           busy,
    output logic           done,
    output logic           ok,
    output logic [1:0]     err_code,
    output logic [2:0]     width_bytes,
    output logic [15:0]    cmd_set,
    output logic [7:0]     size_log2,
    output logic [SZW-1:0] size_bytes,
    output logic [AW-1:0]  fl_addr,
    output logic           fl_wr,
    output logic           fl_rd,
    output logic [DW-1:0]  fl_wdata,
    input  logic [DW-1:0]  fl_rdata
);
    logic       eng_req;
    logic       eng_ack;
    logic [7:0] eng_ofs;
    logic [7:0] eng_byte;

    nfq_seq #(
        .OFS_ID(OFS_ID), .OFS_VEND(OFS_VEND),
        .OFS_SIZE(OFS_SIZE), .OFS_IFACE(OFS_IFACE)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .preset_width(preset_width),
        .ack(eng_ack), .qbyte(eng_byte), .req(eng_req), .ofs(eng_ofs),
        .busy(busy), .done(done), .ok(ok), .err_code(err_code),
        .width_bytes(width_bytes), .cmd_set(cmd_set), .size_log2(size_log2)
    );

    nfq_qry_engine #(
        .AW(AW), .DW(DW), .QRY_ADDR(QRY_ADDR),
        .QRY_CMD(QRY_CMD), .EXIT_CMD(EXIT_CMD)
    ) i_eng (
        .clk(clk), .rst_n(rst_n), .req(eng_req), .ofs(eng_ofs),
        .width(width_bytes), .ack(eng_ack), .qbyte(eng_byte),
        .fl_addr(fl_addr), .fl_wr(fl_wr), .fl_rd(fl_rd),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
    );

    nfq_size_dec #(.SZW(SZW)) i_size (
        .exp_in(size_log2), .bytes_out(size_bytes)
    );
endmodule

// File: rtl/nfq_probe_chk.sv
// Checker: bus-protocol and handshake properties of nfq_probe.
// Assumes: attached through the bind below with matching parameters.
module nfq_probe_chk #(
    parameter int         AW       = 24,
    parameter int         DW       = 32,
    parameter logic [7:0] QRY_CMD  = 8'h98,
    parameter logic [7:0] EXIT_CMD = 8'hFF
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          ok,
    input logic [1:0]    err_code,
    input logic [2:0]    width_bytes,
    input logic [15:0]   cmd_set,
    input logic [AW-1:0] fl_addr,
    input logic          fl_wr,
    input logic          fl_rd,
    input logic [DW-1:0] fl_wdata
);
    a_r1_read_after_enter: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd |-> $past(fl_wr) && $past(fl_wdata) == DW'(QRY_CMD));
    a_r1_exit_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd |=> fl_wr && fl_wdata == DW'(EXIT_CMD) && fl_addr == '0);
    a_r1_write_values: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr |-> (fl_wdata == DW'(QRY_CMD)) || (fl_wdata == DW'(EXIT_CMD)));
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_wr || fl_rd) |-> ((width_bytes == 3'd1) ||
        (width_bytes == 3'd2 && !fl_addr[0]) ||
        (width_bytes == 3'd4 && fl_addr[1:0] == 2'b00)));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(ok) && $stable(err_code) &&
        $stable(width_bytes) && $stable(cmd_set));
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fl_wr && !fl_rd);
    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind nfq_probe nfq_probe_chk #(
    .AW(AW), .DW(DW), .QRY_CMD(QRY_CMD), .EXIT_CMD(EXIT_CMD)
) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ok(ok), .err_code(err_code), .width_bytes(width_bytes),
    .cmd_set(cmd_set), .fl_addr(fl_addr), .fl_wr(fl_wr), .fl_rd(fl_rd),
    .fl_wdata(fl_wdata)
);

// File: tb/test_nfq_probe.sv
// Bench: directed scenarios against a behavioural flash model.
module test_nfq_probe;
    localparam int AW = 24, DW = 32, SZW = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [2:0]     preset_width = 3'd0;
    logic           busy, done, ok;
    logic [1:0]     err_code;
    logic [2:0]     width_bytes;
    logic [15:0]    cmd_set;
    logic [7:0]     size_log2;
    logic [SZW-1:0] size_bytes;
    logic [AW-1:0]  fl_addr;
    logic           fl_wr, fl_rd;
    logic [DW-1:0]  fl_wdata;
    logic [DW-1:0]  fl_rdata;

    int n_chk = 0, n_bad = 0;
    int n_rd = 0, n_wr = 0;
    int dev_w = 0;
    logic qmode = 1'b0;
    logic [7:0] qtab [256];

    always #4 clk = ~clk;

    nfq_probe i_nfq_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .preset_width(preset_width),
        .busy(busy), .done(done), .ok(ok), .err_code(err_code),
        .width_bytes(width_bytes), .cmd_set(cmd_set), .size_log2(size_log2),
        .size_bytes(size_bytes), .fl_addr(fl_addr), .fl_wr(fl_wr),
        .fl_rd(fl_rd), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
    );

    // Flash model: query mode only when the command hits its own scaled address.
    always_comb begin
        if (qmode && dev_w != 0)
            fl_rdata = {24'h0, qtab[(int'(fl_addr) / dev_w) % 256]};
        else
            fl_rdata = 32'hFFFF_FFFF;
    end

    always @(posedge clk) begin
        if (fl_wr) begin
            n_wr <= n_wr + 1;
            if (dev_w != 0 && fl_wdata[7:0] == 8'h98 && int'(fl_addr) == 85 * dev_w)
                qmode <= 1'b1;
            if (fl_wdata[7:0] == 8'hFF && fl_addr == '0)
                qmode <= 1'b0;
        end
        if (fl_rd) n_rd <= n_rd + 1;
    end

    task automatic chk(input bit good, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic load_dev(input int w, input logic [15:0] vend,
                            input logic [7:0] sz, input logic [15:0] ifc);
        for (int i = 0; i < 256; i++) qtab[i] = 8'h00;
        qtab[8'h10] = 8'h51; qtab[8'h11] = 8'h52; qtab[8'h12] = 8'h59;
        qtab[8'h13] = vend[7:0]; qtab[8'h14] = vend[15:8];
        qtab[8'h27] = sz;
        qtab[8'h28] = ifc[7:0]; qtab[8'h29] = ifc[15:8];
        dev_w = w;
    endtask

    // Start one probe, wait for done, return bus access counts.
    task automatic probe(input logic [2:0] pw, input bit poke_busy,
                         output int rds, output int wrs);
        int rd0, wr0, cyc;
        bit seen;
        @(negedge clk);
        rd0 = n_rd; wr0 = n_wr;
        start = 1'b1; preset_width = pw;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", 32'(busy), 32'd1);
        seen = 1'b0;
        cyc = 0;
        while (!seen && cyc < 400) begin
            if (poke_busy && cyc == 3) begin
                start = 1'b1; preset_width = 3'd3;
            end else begin
                start = 1'b0;
            end
            if (done) seen = 1'b1;
            else begin @(negedge clk); cyc++; end
        end
        start = 1'b0;
        chk(seen, "R9 done seen", 32'(seen), 32'd1);
        rds = n_rd - rd0; wrs = n_wr - wr0;
    endtask

    // Check outputs at done, then that they hold and done drops.
    task automatic expect_res(input string tag, input bit e_ok, input logic [1:0] e_err,
                              input logic [2:0] e_w, input logic [15:0] e_cs,
                              input logic [7:0] e_sz, input int rds, input int e_rds);
        chk(ok == e_ok, {tag, " ok"}, 32'(ok), 32'(e_ok));
        chk(err_code == e_err, {tag, " err_code"}, 32'(err_code), 32'(e_err));
        chk(width_bytes == e_w, {tag, " width"}, 32'(width_bytes), 32'(e_w));
        if (e_ok) begin
            chk(cmd_set == e_cs, {tag, " cmd_set (R6)"}, 32'(cmd_set), 32'(e_cs));
            chk(size_log2 == e_sz, {tag, " size_log2 (R7)"}, 32'(size_log2), 32'(e_sz));
        end
        chk(rds == e_rds, {tag, " read count (R1/R3)"}, 32'(rds), 32'(e_rds));
        repeat (3) @(negedge clk);
        chk(!done && !busy, {tag, " R9 done one cycle"}, 32'({busy, done}), 32'd0);
        chk(err_code == e_err && width_bytes == e_w, {tag, " R9 hold"},
            32'({err_code, width_bytes}), 32'({e_err, e_w}));
        chk(qmode == 1'b0, {tag, " R1 device back in array mode"}, 32'(qmode), 32'd0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !ok && err_code == 0 && width_bytes == 0 && cmd_set == 0,
            "R10 reset state", 32'({busy, done, ok, err_code, width_bytes}), 32'd0);
        chk(!fl_wr && !fl_rd, "R10 quiet bus after reset", 32'({fl_wr, fl_rd}), 32'd0);
    endtask

    task automatic t_auto_x1();
        int r, w;
        load_dev(1, 16'h0002, 8'd22, 16'h0000);
        probe(3'd0, 1'b0, r, w);
        expect_res("R3 auto x1", 1'b1, 2'd0, 3'd1, 16'h0002, 8'd22, r, 8);
        chk(w == 16, "R1 write count x1", 32'(w), 32'd16);
        chk(size_bytes == 32'h0040_0000, "R7 size bytes", size_bytes, 32'h0040_0000);
    endtask

    task automatic t_auto_x2();
        int r, w;
        load_dev(2, 16'h0001, 8'd24, 16'h0001);
        probe(3'd0, 1'b0, r, w);
        expect_res("R3 auto x2", 1'b1, 2'd0, 3'd2, 16'h0001, 8'd24, r, 9);
    endtask

    task automatic t_auto_x4();
        int r, w;
        load_dev(4, 16'h1234, 8'd31, 16'h0003);
        probe(3'd0, 1'b0, r, w);
        expect_res("R3 auto x4", 1'b1, 2'd0, 3'd4, 16'h1234, 8'd31, r, 10);
        chk(size_bytes == 32'h8000_0000, "R7 size top bit", size_bytes, 32'h8000_0000);
    endtask

    task automatic t_absent();
        int r, w;
        load_dev(0, 16'h0, 8'd0, 16'h0);
        probe(3'd0, 1'b0, r, w);
        expect_res("R3 no device", 1'b0, 2'd1, 3'd0, 16'h0, 8'd0, r, 3);
    endtask

    task automatic t_preset_miss();
        int r, w;
        load_dev(1, 16'h0002, 8'd20, 16'h0000);
        probe(3'd2, 1'b0, r, w);
        expect_res("R4 preset miss", 1'b0, 2'd1, 3'd0, 16'h0, 8'd0, r, 1);
    endtask

    task automatic t_preset_hit();
        int r, w;
        load_dev(2, 16'h0003, 8'd23, 16'h0005);
        probe(3'd2, 1'b0, r, w);
        expect_res("R4 preset hit", 1'b1, 2'd0, 3'd2, 16'h0003, 8'd23, r, 8);
    endtask

    task automatic t_preset_bad();
        int r, w;
        load_dev(1, 16'h0002, 8'd20, 16'h0000);
        probe(3'd3, 1'b0, r, w);
        expect_res("R4 bad preset", 1'b0, 2'd1, 3'd0, 16'h0, 8'd0, r, 0);
        chk(w == 0, "R4 bad preset no writes", 32'(w), 32'd0);
    endtask

    task automatic t_bad_r();
        int r, w;
        load_dev(1, 16'h0002, 8'd20, 16'h0000);
        qtab[8'h11] = 8'h58;
        probe(3'd0, 1'b0, r, w);
        expect_res("R5 bad R", 1'b0, 2'd2, 3'd1, 16'h0, 8'd0, r, 2);
    endtask

    task automatic t_bad_y();
        int r, w;
        load_dev(2, 16'h0002, 8'd20, 16'h0001);
        qtab[8'h12] = 8'h00;
        probe(3'd0, 1'b0, r, w);
        expect_res("R5 bad Y", 1'b0, 2'd2, 3'd2, 16'h0, 8'd0, r, 4);
    endtask

    task automatic t_iface_bad();
        int r, w;
        load_dev(2, 16'h0002, 8'd20, 16'h0000);
        probe(3'd0, 1'b0, r, w);
        expect_res("R8 iface x2 unsupported", 1'b0, 2'd3, 3'd2, 16'h0, 8'd0, r, 9);
        load_dev(1, 16'h0002, 8'd20, 16'hFFFF);
        probe(3'd0, 1'b0, r, w);
        expect_res("R8 iface wrap", 1'b0, 2'd3, 3'd1, 16'h0, 8'd0, r, 8);
    endtask

    task automatic t_big_size();
        int r, w;
        load_dev(1, 16'h0002, 8'd40, 16'h0000);
        probe(3'd0, 1'b0, r, w);
        expect_res("R7 big exponent", 1'b1, 2'd0, 3'd1, 16'h0002, 8'd40, r, 8);
        chk(size_bytes == 0, "R7 size out of range", size_bytes, 32'd0);
    endtask

    task automatic t_start_busy();
        int r, w;
        load_dev(4, 16'h0002, 8'd21, 16'h0003);
        probe(3'd0, 1'b1, r, w);
        expect_res("R10 start while busy", 1'b1, 2'd0, 3'd4, 16'h0002, 8'd21, r, 10);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_auto_x1();
        t_auto_x2();
        t_auto_x4();
        t_absent();
        t_preset_miss();
        t_preset_hit();
        t_preset_bad();
        t_bad_r();
        t_bad_y();
        t_iface_bad();
        t_big_size();
        t_start_busy();
        finish_run();
    end
endmodule